// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block carries register writes from a fast bus clock into a slow counter clock domain (tens of kHz) where the timekeeping registers live. Each of seven slow-domain registers has its own channel. A bus write to a channel is caught in that channel's holding register. A request toggle then crosses into the slow domain through a two-flop synchronizer. The slow side copies the held value into its applied register, pulses an update strobe and sends an acknowledge toggle back through another two-flop synchronizer.

Software in the fast domain polls a busy bit for each channel. It uses the busy bit of the write it issued to know when the value has landed and a dependent write may follow. An aggregate bit reports whether any channel is still in flight. A write aimed at a channel that is still busy is refused, and the bridge flags the refusal with a one-cycle error pulse.

Top module: `slow_wr_bridge`

## Requirements
- R1: After reset, every busy bit, `any_busy`, `wr_err`, every `s_upd` bit and every applied value `s_val` are zero.
- R2: A write (`wr_en` high, `wr_sel` below 7, that channel not busy) sets `busy[wr_sel]` in the first fast cycle after the write edge. The bit stays set until the acknowledge returns.
- R3: `any_busy` is high exactly when at least one busy bit is high.
- R4: Each accepted write causes exactly one `s_upd[ch]` pulse, one slow cycle long. In that cycle `s_val[ch]` carries the written data.
- R5: A write to a channel whose busy bit is set has no effect on that channel's busy bit, its applied value or its update strobe. `wr_err` is high for the fast cycle following that write.
- R6: While a channel is busy, its holding register does not change.
- R7: Channels are independent. Channel codes on `wr_sel`: 0 control, 1 seconds alarm, 2 tick alarm, 3 seconds-counter load, 4 tick-counter load, 5 tick interrupt clear, 6 seconds interrupt clear. A write to one channel changes no other channel's busy bit or value.
- R8: A write with `wr_sel` of 7 or more sets no busy bit, causes no update and raises no error.
- R9: A busy bit falls only after the slow domain has applied the value, so `s_val` already holds the data when software sees busy clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Fast bus clock |
| frst_n | input | 1 | Fast-domain asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one fast cycle per write |
| wr_sel | input | 3 | Channel code of the write |
| wr_data | input | 32 | Write data |
| busy | output | 7 | Per-channel write-in-flight bits |
| any_busy | output | 1 | OR of all busy bits |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| sclk | input | 1 | Slow counter clock |
| srst_n | input | 1 | Slow-domain asynchronous active-low reset |
| s_val | output | 7x32 | Applied value per channel, slow domain |
| s_upd | output | 7 | One-slow-cycle pulse per applied write |

## Verification
The assertions assume three things about the inputs. `wr_sel` and `wr_data` are settled whenever `wr_en` is sampled. The two clocks are unrelated. The slow clock is slow enough that a request toggle never changes twice within one slow period. Under these conditions a slow-side update strobe can never repeat on consecutive slow edges.

The stimulus keeps within these conditions. It drives every input on the falling fast edge and keeps the slow period fifty times the fast one. It also waits for each channel's busy bit to drop before writing that channel again, except when it deliberately tests refusal.

// File: rtl/slow_wr_pkg.sv
package slow_wr_pkg;
  localparam int CH_COUNT = 7;
  localparam int WORD_W   = 32;

  typedef enum logic [2:0] {
    CH_CTRL      = 3'd0,
    CH_SEC_ALM   = 3'd1,
    CH_TICK_ALM  = 3'd2,
    CH_SEC_LOAD  = 3'd3,
    CH_TICK_LOAD = 3'd4,
    CH_TICK_CLR  = 3'd5,
    CH_SEC_CLR   = 3'd6
  } chan_e;
endpackage

// File: rtl/swb_sync2.sv
module swb_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/swb_rst_sync.sv
module swb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n   <= stage_q;
    end
  end
endmodule

// File: rtl/swb_fast_chan.sv
module swb_fast_chan #(
  parameter int DW = 32
) (
  input  logic          fclk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] data,
  input  logic          ack_tgl,
  output logic          busy,
  output logic          reject,
  output logic          req_tgl,
  output logic [DW-1:0] hold
);
  logic          ack_s;
  logic          accept;
  logic          req_d;
  logic [DW-1:0] hold_d;

  swb_sync2 u_ack_sync (
    .clk  (fclk),
    .rst_n(rst_n),
    .d    (ack_tgl),
    .q    (ack_s)
  );

  assign busy   = req_tgl ^ ack_s;
  assign accept = hit & ~busy;
  assign reject = hit & busy;

  always_comb begin
    req_d  = req_tgl;
    hold_d = hold;
    if (accept) begin
      req_d  = ~req_tgl;
      hold_d = data;
    end
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      hold    <= '0;
    end else begin
      req_tgl <= req_d;
      hold    <= hold_d;
    end
  end
endmodule

// File: rtl/swb_slow_chan.sv
module swb_slow_chan #(
  parameter int DW = 32
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          req_tgl,
  input  logic [DW-1:0] hold,
  output logic          ack_tgl,
  output logic [DW-1:0] val,
  output logic          upd
);
  logic          req_s;
  logic          apply;
  logic          ack_d;
  logic          upd_d;
  logic [DW-1:0] val_d;

  swb_sync2 u_req_sync (
    .clk  (sclk),
    .rst_n(rst_n),
    .d    (req_tgl),
    .q    (req_s)
  );

  assign apply = req_s ^ ack_tgl;

  always_comb begin
    ack_d = ack_tgl;
    val_d = val;
    upd_d = 1'b0;
    if (apply) begin
      ack_d = req_s;
      val_d = hold;
      upd_d = 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl <= 1'b0;
      val     <= '0;
      upd     <= 1'b0;
    end else begin
      ack_tgl <= ack_d;
      val     <= val_d;
      upd     <= upd_d;
    end
  end
endmodule

// File: rtl/slow_wr_bridge.sv
module slow_wr_bridge #(
  parameter int NUM_CH = slow_wr_pkg::CH_COUNT,
  parameter int DW     = slow_wr_pkg::WORD_W,
  localparam int SELW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     fclk,
  input  logic                     frst_n,
  input  logic                     wr_en,
  input  logic [SELW-1:0]          wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic [NUM_CH-1:0]        busy,
  output logic                     any_busy,
  output logic                     wr_err,
  input  logic                     sclk,
  input  logic                     srst_n,
  output logic [NUM_CH-1:0][DW-1:0] s_val,
  output logic [NUM_CH-1:0]        s_upd
);
  logic                      f_rst_q;
  logic                      s_rst_q;
  logic [NUM_CH-1:0]         hit;
  logic [NUM_CH-1:0]         reject;
  logic [NUM_CH-1:0]         req_tgl;
  logic [NUM_CH-1:0]         ack_tgl;
  logic [NUM_CH-1:0][DW-1:0] hold_w;
  logic                      err_d;

  swb_rst_sync u_frst (.clk(fclk), .arst_n(frst_n), .rst_n(f_rst_q));
  swb_rst_sync u_srst (.clk(sclk), .arst_n(srst_n), .rst_n(s_rst_q));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign hit[ch] = wr_en && (wr_sel == SELW'(ch));

    swb_fast_chan #(.DW(DW)) u_fast (
      .fclk   (fclk),
      .rst_n  (f_rst_q),
      .hit    (hit[ch]),
      .data   (wr_data),
      .ack_tgl(ack_tgl[ch]),
      .busy   (busy[ch]),
      .reject (reject[ch]),
      .req_tgl(req_tgl[ch]),
      .hold   (hold_w[ch])
    );

    swb_slow_chan #(.DW(DW)) u_slow (
      .sclk   (sclk),
      .rst_n  (s_rst_q),
      .req_tgl(req_tgl[ch]),
      .hold   (hold_w[ch]),
      .ack_tgl(ack_tgl[ch]),
      .val    (s_val[ch]),
      .upd    (s_upd[ch])
    );
  end

  assign any_busy = |busy;
  assign err_d    = |reject;

  always_ff @(posedge fclk or negedge f_rst_q) begin
    if (!f_rst_q) begin
      wr_err <= 1'b0;
    end else begin
      wr_err <= err_d;
    end
  end
endmodule

// File: rtl/slow_wr_bridge_chk.sv
module slow_wr_bridge_chk #(
  parameter int NUM_CH = 7,
  parameter int DW     = 32,
  parameter int SELW   = 3
) (
  input logic                      fclk,
  input logic                      f_rst_n,
  input logic                      sclk,
  input logic                      s_rst_n,
  input logic                      wr_en,
  input logic [SELW-1:0]           wr_sel,
  input logic [NUM_CH-1:0]         busy,
  input logic                      any_busy,
  input logic                      wr_err,
  input logic [NUM_CH-1:0]         s_upd,
  input logic [NUM_CH-1:0][DW-1:0] hold
);
  a_r8_invalid_sel_quiet: assert property (@(posedge fclk) disable iff (!f_rst_n)
    (wr_en && (32'(wr_sel) >= NUM_CH)) |=> !wr_err);

  a_r3_summary_clear: assert property (@(posedge fclk) disable iff (!f_rst_n)
    $fell(any_busy) |-> (busy == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    a_r2_busy_rise: assert property (@(posedge fclk) disable iff (!f_rst_n)
      (wr_en && wr_sel == SELW'(ch) && !busy[ch]) |=> busy[ch]);

    a_r5_reject_err: assert property (@(posedge fclk) disable iff (!f_rst_n)
      (wr_en && wr_sel == SELW'(ch) && busy[ch]) |=> (wr_err && busy[ch]));

    a_r6_hold_stable: assert property (@(posedge fclk) disable iff (!f_rst_n)
      ($past(busy[ch]) && busy[ch]) |-> $stable(hold[ch]));

    a_r4_single_upd: assert property (@(posedge sclk) disable iff (!s_rst_n)
      s_upd[ch] |=> !s_upd[ch]);
  end
endmodule

bind slow_wr_bridge slow_wr_bridge_chk #(
  .NUM_CH(NUM_CH),
  .DW    (DW),
  .SELW  (SELW)
) u_chk (
  .fclk    (fclk),
  .f_rst_n (f_rst_q),
  .sclk    (sclk),
  .s_rst_n (s_rst_q),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .busy    (busy),
  .any_busy(any_busy),
  .wr_err  (wr_err),
  .s_upd   (s_upd),
  .hold    (hold_w)
);

// File: tb/tb_slow_wr_bridge.sv
`timescale 1ns/1ps
module tb_slow_wr_bridge;
  localparam int NCH = 7;
  localparam int DW  = 32;

  logic                   fclk = 1'b0;
  logic                   sclk = 1'b0;
  logic                   frst_n, srst_n;
  logic                   wr_en;
  logic [2:0]             wr_sel;
  logic [DW-1:0]          wr_data;
  logic [NCH-1:0]         busy;
  logic                   any_busy, wr_err;
  logic [NCH-1:0][DW-1:0] s_val;
  logic [NCH-1:0]         s_upd;

  typedef struct { int ch; logic [DW-1:0] data; } item_t;
  item_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2   fclk = ~fclk;
  always #100 sclk = ~sclk;

  slow_wr_bridge dut (
    .fclk(fclk), .frst_n(frst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .busy(busy), .any_busy(any_busy), .wr_err(wr_err),
    .sclk(sclk), .srst_n(srst_n), .s_val(s_val), .s_upd(s_upd)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected applies in the slow domain (R4, R5).
  always @(negedge sclk) begin
    if (srst_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (s_upd[ch]) begin
          int idx = -1;
          for (int k = 0; k < exp_q.size(); k++)
            if (idx < 0 && exp_q[k].ch == ch) idx = k;
          if (idx < 0) begin
            chk(1'b0, "R4/R5 unexpected update", 64'(ch), 64'hFF);
          end else begin
            chk(s_val[ch] == exp_q[idx].data, "R4 applied value", 64'(s_val[ch]), 64'(exp_q[idx].data));
            exp_q.delete(idx);
          end
        end
      end
    end
  end

  // Driver: one write, checks busy/err right after the capture edge.
  task automatic do_write(input int ch, input logic [DW-1:0] d, input bit expect_ok);
    logic [NCH-1:0] busy_before;
    busy_before = busy;
    wr_en = 1'b1; wr_sel = 3'(ch); wr_data = d;
    @(negedge fclk);
    wr_en = 1'b0;
    wr_data = ~d;
    if (ch >= NCH) begin
      chk(busy == busy_before, "R8 busy unchanged", 64'(busy), 64'(busy_before));
      chk(wr_err == 1'b0, "R8 no error", 64'(wr_err), 0);
    end else if (expect_ok) begin
      exp_q.push_back('{ch, d});
      chk(busy[ch] == 1'b1, "R2 busy rises", 64'(busy[ch]), 1);
      chk(any_busy == 1'b1, "R3 any_busy set", 64'(any_busy), 1);
      chk(wr_err == 1'b0, "R2 no error on accept", 64'(wr_err), 0);
    end else begin
      chk(wr_err == 1'b1, "R5 error pulse", 64'(wr_err), 1);
      chk(busy[ch] == 1'b1, "R5 busy kept", 64'(busy[ch]), 1);
      @(negedge fclk);
      chk(wr_err == 1'b0, "R5 error one cycle", 64'(wr_err), 0);
    end
  endtask

  task automatic wait_idle(input int ch, input logic [DW-1:0] d);
    int n = 0;
    while (busy[ch] && n < 2000) begin
      @(negedge fclk);
      n++;
    end
    chk(!busy[ch], "R2 busy clears", 64'(busy[ch]), 0);
    chk(s_val[ch] == d, "R9 value applied before busy clears", 64'(s_val[ch]), 64'(d));
  endtask

  initial begin
    frst_n = 1'b0; srst_n = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (5) @(negedge sclk);
    @(negedge fclk);
    chk(busy == '0 && !any_busy && !wr_err, "R1 fast reset state", 64'({busy, any_busy, wr_err}), 0);
    chk(s_val == '0 && s_upd == '0, "R1 slow reset state", 64'(s_val[0]), 0);
    frst_n = 1'b1; srst_n = 1'b1;
    repeat (3) @(negedge sclk);
    @(negedge fclk);

    // R2 R4 R9: single write on control channel
    do_write(0, 32'hA5A5_0001, 1);
    wait_idle(0, 32'hA5A5_0001);
    chk(!any_busy, "R3 any_busy low when idle", 64'(any_busy), 0);

    // R5: second write while busy is refused
    do_write(1, 32'h0000_1234, 1);
    do_write(1, 32'hDEAD_BEEF, 0);
    wait_idle(1, 32'h0000_1234);
    repeat (400) @(negedge fclk);
    chk(s_val[1] == 32'h0000_1234, "R5 refused data never applied", 64'(s_val[1]), 64'h1234);

    // R7: concurrent writes on several channels
    do_write(2, 32'h0000_7FFF, 1);
    do_write(3, 32'h0001_0000, 1);
    do_write(6, 32'h0000_0001, 1);
    chk(busy == 7'b100_1100, "R7 busy pattern", 64'(busy), 64'h4C);
    chk(s_val[0] == 32'hA5A5_0001, "R7 other channel untouched", 64'(s_val[0]), 64'hA5A50001);
    wait_idle(2, 32'h0000_7FFF);
    wait_idle(3, 32'h0001_0000);
    wait_idle(6, 32'h0000_0001);

    // R8: out-of-range select
    do_write(7, 32'hFFFF_FFFF, 1);
    repeat (400) @(negedge fclk);
    chk(busy == '0, "R8 nothing pending", 64'(busy), 0);

    // R6: data bus changes after capture do not leak through
    do_write(4, 32'h1357_9BDF, 1);
    wr_data = 32'h0;
    wait_idle(4, 32'h1357_9BDF);
    do_write(5, 32'hFFFF_FFFF, 1);
    wait_idle(5, 32'hFFFF_FFFF);

    repeat (5) @(negedge sclk);
    chk(exp_q.size() == 0, "R4 all writes applied", 64'(exp_q.size()), 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(negedge fclk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule